// File: doc/BRIEF.md
# Configurable Crosspoint Pin Cell

This block is the per-pin slice of a programmable signal crosspoint. Four routed data lanes arrive from the routing fabric. Two routed select lines pick one of them on every cycle, with a Gray-coded mapping. Per-cell configuration bits then shape the result. Each routed control (output enable, storage clock and both selects) has its own polarity inversion. A single storage element can act as an edge-triggered register, as a transparent latch, or be bypassed. It can sit either on the way out to the pin or on the way in from the pin towards the router. The driven value can be inverted, or replaced by a constant high or low level so the pin behaves as a jumper or switch.

The routed storage clock is treated as a data signal and sampled against the chip clock `clk`. An "edge" of the storage clock is therefore a cycle in which the polarity-adjusted clock is seen high after having been low. The latch mode is truly transparent: while the adjusted clock is high, the data passes straight through in the same cycle. An asynchronous active-low reset tri-states the pin and clears the storage element.

Top module: `xp_cell`

## Requirements
- R1: With the adjusted selects written as {hi,lo}, the selected lane is 00 → lane A, 01 → lane B, 11 → lane C, 10 → lane D.
- R2: Each select line is XORed with its own inversion bit before decoding. Inverting one line moves the choice to the lane whose code differs in that bit.
- R3: Outside jumper mode and out of reset, the pin enable equals the routed enable XOR its inversion bit.
- R4: Storage mode 1 (edge register) loads its input only in a cycle where the adjusted clock (raw clock XOR clock inversion bit) is high and was low in the previous cycle. The first cycle after reset counts as "previously high", so it never loads. Otherwise the stored value holds.
- R5: Storage mode 2 (latch) passes its input in the same cycle while the adjusted clock is high. It holds the last passed value while the adjusted clock is low.
- R6: Storage modes 0 and 3 bypass the storage element, so the path is purely combinational.
- R7: With placement bit 0 (output placement), the storage element is fed by the selected lane and drives the pin, and the value returned to the router is the pin input.
- R8: With placement bit 1 (input placement), the storage element is fed by the pin input and drives the value returned to the router, and the pin value is the selected lane with no storage.
- R9: When the output inversion bit is set outside jumper mode, every pin bit is the inverse of the value the path delivers.
- R10: In jumper mode every pin bit equals the jumper level bit and the pin is enabled, whatever the lanes, selects, enable and inversion bits.
- R11: While reset is low the pin enable is 0 and the storage element is cleared, so a held edge-register output reads all zeros after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock that samples the routed storage clock |
| rstN | input | 1 | Asynchronous active-low reset |
| laneA | input | WIDTH | Routed data lane A |
| laneB | input | WIDTH | Routed data lane B |
| laneC | input | WIDTH | Routed data lane C |
| laneD | input | WIDTH | Routed data lane D |
| selLo | input | 1 | Routed select, low bit |
| selHi | input | 1 | Routed select, high bit |
| oeIn | input | 1 | Routed output enable |
| stClkIn | input | 1 | Routed storage clock |
| pinIn | input | WIDTH | Value read back from the pin |
| cfgSelLoInv | input | 1 | Inversion of the low select |
| cfgSelHiInv | input | 1 | Inversion of the high select |
| cfgOeInv | input | 1 | Inversion of the output enable |
| cfgClkInv | input | 1 | Inversion of the storage clock |
| cfgStore | input | 2 | Storage mode: 0 bypass, 1 edge register, 2 latch, 3 bypass |
| cfgInPlace | input | 1 | 0 places storage on the pin path, 1 on the router path |
| cfgOutInv | input | 1 | Output value inversion |
| cfgJumper | input | 1 | Jumper mode enable |
| cfgJumperLvl | input | 1 | Constant level driven in jumper mode |
| pinOut | output | WIDTH | Value driven to the pin |
| pinOe | output | 1 | Pin drive enable |
| toRouter | output | WIDTH | Value returned to the routing fabric |

## Verification
The bench sweeps all four select codes under all four select-inversion combinations. A decoder that used binary order would swap lanes C and D. A decoder that applied an inversion to the wrong line would pick a neighbour lane. In register mode the storage clock is held high across reset release and later toggled under both clock polarities. A design that loaded on levels, on the wrong edge, or on the first cycle after reset would show data that should still be held. Latch runs check same-cycle passthrough and the hold once the clock drops. Placement and jumper runs confirm that the router return and the pin each take the right source, and that jumper mode overrides inversion and enable.

// File: rtl/xp_cell_pkg.sv
package xp_cell_pkg;

  typedef enum logic [1:0] {
    STORE_BYPASS = 2'd0,
    STORE_EDGE   = 2'd1,
    STORE_LATCH  = 2'd2,
    STORE_SPARE  = 2'd3
  } storeMode_e;

  // strobes handed from the control to the datapath
  typedef struct packed {
    logic [1:0] laneSel;    // adjusted {hi,lo} select
    logic       load;       // storage element takes its input this cycle
    logic       passThru;   // stage output follows its input combinationally
    logic       inPlace;    // storage sits on the router path
    logic       outInv;
    logic       jumper;
    logic       jumperLvl;
  } cellCtrl_t;

endpackage

// File: rtl/xp_cell_ctrl.sv
module xp_cell_ctrl
  import xp_cell_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selLo,
  input  logic       selHi,
  input  logic       oeIn,
  input  logic       stClkIn,
  input  logic       cfgSelLoInv,
  input  logic       cfgSelHiInv,
  input  logic       cfgOeInv,
  input  logic       cfgClkInv,
  input  logic [1:0] cfgStore,
  input  logic       cfgInPlace,
  input  logic       cfgOutInv,
  input  logic       cfgJumper,
  input  logic       cfgJumperLvl,
  output cellCtrl_t  ctrl,
  output logic       pinOe
);

  storeMode_e mode;
  logic effClk;
  logic clkPrev;
  logic clkRise;
  logic isEdge;
  logic isLatch;

  assign mode    = storeMode_e'(cfgStore);
  assign effClk  = stClkIn ^ cfgClkInv;
  assign clkRise = effClk & ~clkPrev;
  assign isEdge  = (mode == STORE_EDGE);
  assign isLatch = (mode == STORE_LATCH);

  // previous level starts high so a clock already high at release is not an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= 1'b1;
    else       clkPrev <= effClk;
  end

  always_comb begin
    ctrl.laneSel   = {selHi ^ cfgSelHiInv, selLo ^ cfgSelLoInv};
    ctrl.load      = (isEdge & clkRise) | (isLatch & effClk);
    ctrl.passThru  = ~(isEdge | isLatch) | (isLatch & effClk);
    ctrl.inPlace   = cfgInPlace;
    ctrl.outInv    = cfgOutInv;
    ctrl.jumper    = cfgJumper;
    ctrl.jumperLvl = cfgJumperLvl;
  end

  always_comb begin
    if (!rstN)          pinOe = 1'b0;
    else if (cfgJumper) pinOe = 1'b1;
    else                pinOe = oeIn ^ cfgOeInv;
  end

endmodule

// File: rtl/xp_cell_dp.sv
module xp_cell_dp
  import xp_cell_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  cellCtrl_t        ctrl,
  input  logic [WIDTH-1:0] laneA,
  input  logic [WIDTH-1:0] laneB,
  input  logic [WIDTH-1:0] laneC,
  input  logic [WIDTH-1:0] laneD,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] toRouter
);

  localparam int LANES = 4;

  logic [LANES-1:0][WIDTH-1:0] lanes;
  logic [WIDTH-1:0] muxOut;
  logic [WIDTH-1:0] stageIn;
  logic [WIDTH-1:0] stageOut;
  logic [WIDTH-1:0] outPath;

  assign lanes[0] = laneA;
  assign lanes[1] = laneB;
  assign lanes[2] = laneD;  // code 10
  assign lanes[3] = laneC;  // code 11

  assign muxOut  = lanes[ctrl.laneSel];
  assign stageIn = ctrl.inPlace ? pinIn : muxOut;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic held;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          held <= 1'b0;
      else if (ctrl.load) held <= stageIn[b];
    end

    assign stageOut[b] = ctrl.passThru ? stageIn[b] : held;
  end

  assign outPath  = ctrl.inPlace ? muxOut : stageOut;
  assign toRouter = ctrl.inPlace ? stageOut : pinIn;
  assign pinOut   = ctrl.jumper ? {WIDTH{ctrl.jumperLvl}}
                                : (outPath ^ {WIDTH{ctrl.outInv}});

endmodule

// File: rtl/xp_cell.sv
module xp_cell
  import xp_cell_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] laneA,
  input  logic [WIDTH-1:0] laneB,
  input  logic [WIDTH-1:0] laneC,
  input  logic [WIDTH-1:0] laneD,
  input  logic             selLo,
  input  logic             selHi,
  input  logic             oeIn,
  input  logic             stClkIn,
  input  logic [WIDTH-1:0] pinIn,
  input  logic             cfgSelLoInv,
  input  logic             cfgSelHiInv,
  input  logic             cfgOeInv,
  input  logic             cfgClkInv,
  input  logic [1:0]       cfgStore,
  input  logic             cfgInPlace,
  input  logic             cfgOutInv,
  input  logic             cfgJumper,
  input  logic             cfgJumperLvl,
  output logic [WIDTH-1:0] pinOut,
  output logic             pinOe,
  output logic [WIDTH-1:0] toRouter
);

  cellCtrl_t ctrl;

  xp_cell_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .selLo(selLo), .selHi(selHi), .oeIn(oeIn), .stClkIn(stClkIn),
    .cfgSelLoInv(cfgSelLoInv), .cfgSelHiInv(cfgSelHiInv),
    .cfgOeInv(cfgOeInv), .cfgClkInv(cfgClkInv), .cfgStore(cfgStore),
    .cfgInPlace(cfgInPlace), .cfgOutInv(cfgOutInv),
    .cfgJumper(cfgJumper), .cfgJumperLvl(cfgJumperLvl),
    .ctrl(ctrl), .pinOe(pinOe)
  );

  xp_cell_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .laneA(laneA), .laneB(laneB), .laneC(laneC), .laneD(laneD),
    .pinIn(pinIn), .pinOut(pinOut), .toRouter(toRouter)
  );

endmodule

// File: rtl/xp_cell_chk.sv
module xp_cell_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] laneA,
  input logic [WIDTH-1:0] laneB,
  input logic [WIDTH-1:0] laneC,
  input logic [WIDTH-1:0] laneD,
  input logic             selLo,
  input logic             selHi,
  input logic             oeIn,
  input logic             stClkIn,
  input logic             cfgSelLoInv,
  input logic             cfgSelHiInv,
  input logic             cfgOeInv,
  input logic             cfgClkInv,
  input logic [1:0]       cfgStore,
  input logic             cfgInPlace,
  input logic             cfgOutInv,
  input logic             cfgJumper,
  input logic             cfgJumperLvl,
  input logic [WIDTH-1:0] pinOut,
  input logic             pinOe
);

  logic [1:0] code;
  logic [WIDTH-1:0] picked;
  logic adjClk;
  logic [7:0] cfgBits;

  assign code    = {selHi ^ cfgSelHiInv, selLo ^ cfgSelLoInv};
  assign adjClk  = stClkIn ^ cfgClkInv;
  assign cfgBits = {cfgStore, cfgInPlace, cfgOutInv, cfgJumper, cfgJumperLvl, cfgClkInv, 1'b0};

  always_comb begin
    case (code)
      2'b00:   picked = laneA;
      2'b01:   picked = laneB;
      2'b11:   picked = laneC;
      default: picked = laneD;
    endcase
  end

  // R11
  reset_tristate_chk: assert property (@(posedge clk) !rstN |-> !pinOe);

  // R10
  jumper_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgJumper |-> (pinOe && pinOut == {WIDTH{cfgJumperLvl}}));

  // R3
  oe_polarity_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgJumper |-> (pinOe == (oeIn ^ cfgOeInv)));

  // R1
  lane_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgInPlace && !cfgJumper && !cfgOutInv) |-> (pinOut == picked));

  // R5
  latch_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStore == 2'd2 && !cfgInPlace && !cfgJumper && !cfgOutInv && adjClk)
      |-> (pinOut == picked));

  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStore == 2'd1 && !cfgInPlace && !cfgJumper && $stable(cfgBits)
      && !($past(adjClk) && !$past(adjClk, 2))) |-> $stable(pinOut));

endmodule

bind xp_cell xp_cell_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN),
  .laneA(laneA), .laneB(laneB), .laneC(laneC), .laneD(laneD),
  .selLo(selLo), .selHi(selHi), .oeIn(oeIn), .stClkIn(stClkIn),
  .cfgSelLoInv(cfgSelLoInv), .cfgSelHiInv(cfgSelHiInv),
  .cfgOeInv(cfgOeInv), .cfgClkInv(cfgClkInv), .cfgStore(cfgStore),
  .cfgInPlace(cfgInPlace), .cfgOutInv(cfgOutInv),
  .cfgJumper(cfgJumper), .cfgJumperLvl(cfgJumperLvl),
  .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/tb_xp_cell.sv
`timescale 1ns/1ps
module tb_xp_cell;

  localparam int W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] laneA = '0, laneB = '0, laneC = '0, laneD = '0, pinIn = '0;
  logic selLo = 0, selHi = 0, oeIn = 0, stClkIn = 0;
  logic cfgSelLoInv = 0, cfgSelHiInv = 0, cfgOeInv = 0, cfgClkInv = 0;
  logic [1:0] cfgStore = 2'd0;
  logic cfgInPlace = 0, cfgOutInv = 0, cfgJumper = 0, cfgJumperLvl = 0;
  logic [W-1:0] pinOut, toRouter;
  logic pinOe;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  string curReq = "R11";

  always #2 clk = ~clk;  // 250 MHz

  xp_cell #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN),
    .laneA(laneA), .laneB(laneB), .laneC(laneC), .laneD(laneD),
    .selLo(selLo), .selHi(selHi), .oeIn(oeIn), .stClkIn(stClkIn),
    .pinIn(pinIn),
    .cfgSelLoInv(cfgSelLoInv), .cfgSelHiInv(cfgSelHiInv),
    .cfgOeInv(cfgOeInv), .cfgClkInv(cfgClkInv), .cfgStore(cfgStore),
    .cfgInPlace(cfgInPlace), .cfgOutInv(cfgOutInv),
    .cfgJumper(cfgJumper), .cfgJumperLvl(cfgJumperLvl),
    .pinOut(pinOut), .pinOe(pinOe), .toRouter(toRouter)
  );

  // behavioural reference state
  logic [W-1:0] mStore;
  logic mPrevHigh;

  function automatic logic [W-1:0] pickLane();
    int code;
    code = 2 * int'(selHi ^ cfgSelHiInv) + int'(selLo ^ cfgSelLoInv);
    if (code == 0) return laneA;
    if (code == 1) return laneB;
    if (code == 3) return laneC;
    return laneD;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStore = '0;
      mPrevHigh = 1'b1;
    end else begin
      logic clkHigh;
      logic [W-1:0] src;
      clkHigh = stClkIn ^ cfgClkInv;
      src = cfgInPlace ? pinIn : pickLane();
      if (cfgStore == 2'd1 && clkHigh && !mPrevHigh) mStore = src;
      if (cfgStore == 2'd2 && clkHigh) mStore = src;
      mPrevHigh = clkHigh;
    end
  end

  always @(posedge clk) begin
    #1;
    if (!finished) begin
      logic [W-1:0] src, stage, viaPath, expOut, expRtr;
      logic expOe;
      logic clkHigh;
      clkHigh = stClkIn ^ cfgClkInv;
      src = cfgInPlace ? pinIn : pickLane();
      if (cfgStore == 2'd1) stage = mStore;
      else if (cfgStore == 2'd2) stage = clkHigh ? src : mStore;
      else stage = src;
      viaPath = cfgInPlace ? pickLane() : stage;
      expRtr  = cfgInPlace ? stage : pinIn;
      expOut  = cfgJumper ? {W{cfgJumperLvl}} : (viaPath ^ {W{cfgOutInv}});
      expOe   = !rstN ? 1'b0 : (cfgJumper ? 1'b1 : (oeIn ^ cfgOeInv));
      nChecks++;
      if (pinOut !== expOut || pinOe !== expOe || toRouter !== expRtr) begin
        nFails++;
        $display("FAIL %s: pinOut=%h pinOe=%b toRouter=%h expected pinOut=%h pinOe=%b toRouter=%h",
                 curReq, pinOut, pinOe, toRouter, expOut, expOe, expRtr);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic randLanes();
    laneA = W'($urandom); laneB = W'($urandom);
    laneC = W'($urandom); laneD = W'($urandom);
    pinIn = W'($urandom);
  endtask

  task automatic runRandom(int n, bit toggleClk, bit toggleSel);
    for (int i = 0; i < n; i++) begin
      randLanes();
      if (toggleClk) stClkIn = $urandom_range(0, 1);
      if (toggleSel) begin
        selLo = $urandom_range(0, 1);
        selHi = $urandom_range(0, 1);
      end
      oeIn = $urandom_range(0, 1);
      cyc(1);
    end
  endtask

  initial begin
    // R11: reset state, storage clock high across release
    curReq = "R11";
    oeIn = 1; stClkIn = 1; cfgStore = 2'd1;
    cyc(3);
    rstN = 1;
    randLanes();
    cyc(2);  // R4: clock already high at release, no load

    // R1: lane order under fixed lane patterns
    curReq = "R1";
    cfgStore = 2'd0; stClkIn = 0;
    laneA = 4'h1; laneB = 4'h2; laneC = 4'h4; laneD = 4'h8;
    for (int s = 0; s < 4; s++) begin
      selHi = s[1]; selLo = s[0];
      cyc(1);
    end

    // R2: every inversion combination with every code
    curReq = "R2";
    for (int v = 0; v < 4; v++) begin
      cfgSelHiInv = v[1]; cfgSelLoInv = v[0];
      for (int s = 0; s < 4; s++) begin
        selHi = s[1]; selLo = s[0];
        cyc(1);
      end
    end
    cfgSelHiInv = 0; cfgSelLoInv = 0;

    // R3: enable polarity
    curReq = "R3";
    for (int v = 0; v < 4; v++) begin
      cfgOeInv = v[1]; oeIn = v[0];
      cyc(1);
    end
    cfgOeInv = 0;

    // R6: bypass modes 0 and 3
    curReq = "R6";
    cfgStore = 2'd0; runRandom(10, 1, 1);
    cfgStore = 2'd3; runRandom(10, 1, 1);

    // R9: output inversion
    curReq = "R9";
    cfgOutInv = 1; runRandom(8, 1, 1);
    cfgOutInv = 0;

    // R4: edge register under both clock polarities
    curReq = "R4";
    cfgStore = 2'd1;
    cfgClkInv = 0; runRandom(30, 1, 1);
    cfgClkInv = 1; runRandom(30, 1, 1);
    cfgClkInv = 0;

    // R5: latch pass and hold
    curReq = "R5";
    cfgStore = 2'd2;
    stClkIn = 1; runRandom(5, 0, 1);
    stClkIn = 0; runRandom(5, 0, 1);
    cfgClkInv = 1; runRandom(20, 1, 1);
    cfgClkInv = 0;

    // R7: output placement, router sees the pin
    curReq = "R7";
    cfgInPlace = 0; cfgStore = 2'd1; runRandom(15, 1, 1);

    // R8: input placement in every storage mode
    curReq = "R8";
    cfgInPlace = 1;
    for (int m = 0; m < 4; m++) begin
      cfgStore = m[1:0];
      runRandom(12, 1, 1);
    end
    cfgInPlace = 0;

    // R10: jumper overrides inversion and enable
    curReq = "R10";
    cfgJumper = 1; cfgOutInv = 1; cfgOeInv = 1;
    cfgJumperLvl = 1; runRandom(6, 1, 1);
    cfgJumperLvl = 0; runRandom(6, 1, 1);
    cfgJumper = 0; cfgOutInv = 0; cfgOeInv = 0;

    // R11: reset mid-run clears a held register
    curReq = "R11";
    cfgStore = 2'd1; laneA = 4'hF; selLo = 0; selHi = 0;
    stClkIn = 0; cyc(1);
    stClkIn = 1; cyc(2);
    rstN = 0; cyc(2);
    rstN = 1; stClkIn = 0; cyc(3);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule